// File: doc/BRIEF.md
# Dual-Oscillator Phase-Difference Integrator

This block turns the relative timing of two free-running square-wave oscillators into a signed binary count. Both oscillator inputs are brought into one fast system-clock domain. Each rising edge becomes a single-cycle event. A three-state phase-frequency detector tracks which oscillator fired last without being answered by the other. A sign register records which oscillator leads.

A counting enable runs at the mean rate of the two oscillators. It is formed by merging the edge events of both oscillators and keeping every second one. On each enabled cycle the counter moves by the current three-level detector value. That value is +1 or -1 when the detector is holding a pending edge, with the sign giving the direction, and 0 when the detector is idle. The count saturates at its ends.

The three-level value is also driven out as a two-bit code for a feed-forward path. The sign changes only on a counting cycle, so the counter always sees a settled direction.

Top module: `pdi_top`

## Requirements
- R1: A rising edge on either oscillator input becomes visible at the detector three system-clock cycles after the input changes: two synchronizer flops plus the detector register.
- R2: An edge on oscillator A with the detector idle raises UP, and an edge on oscillator B raises DN. When the pending flag is answered by the other oscillator, both flags clear together. UP and DN are never high at the same time.
- R3: Edges that reach both oscillators' edge detectors in the same system-clock cycle leave UP, DN, the sign and the count unchanged.
- R4: The counting enable fires on the first of every two merged edge events, and never on two consecutive cycles. A detector event that falls on a non-counting event does not move the count.
- R5: The raw sign becomes 1 when A fires from idle and 0 when B fires from idle. The output sign takes the raw sign only on a counting cycle and holds otherwise.
- R6: On a counting cycle the count rises by one when a flag is pending and the sign is 1, and falls by one when a flag is pending and the sign is 0. It holds at 511 going up and at 0 going down, with no wrap-around.
- R7: A synchronous active-high reset sets the count to mid-scale 256, the sign to 0, the detector to idle and the code to 01.
- R8: The code output is 2'b11 for +1 (pending flag, sign 1), 2'b00 for -1 (pending flag, sign 0) and 2'b01 for 0 (idle). The value 2'b10 never appears.
- R9: With oscillator A running at a constant higher frequency than B the count rises, and with B faster it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast oversampling system clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_a | input | 1 | Oscillator A square wave, asynchronous |
| osc_b | input | 1 | Oscillator B square wave, asynchronous |
| count | output | CNT_W | Integrated phase-difference count |
| sign | output | 1 | Leading-oscillator direction, 1 when A leads |
| tcode | output | 2 | Three-level feed-forward code (11 = +1, 01 = 0, 00 = -1) |

## Verification
A cycle-accurate reference model runs beside the design and is compared on every cycle. It is driven with four kinds of stimulus:
- Identical in-phase oscillators. These separate true coincidence rejection from a detector that reacts to either edge.
- A directed sequence of single edges. This pins the three-cycle latency, the timing of the sign hand-over and the skipping of every second merged event.
- A constant frequency offset with A faster, then with B faster. These show the direction of integration and drive the count into both saturation limits.

A reset applied in the middle of a run confirms the return to mid-scale.

// File: rtl/pdi_pkg.sv
package pdi_pkg;

    // Three-level feed-forward code
    typedef enum logic [1:0] {
        TERN_NEG  = 2'b00,
        TERN_ZERO = 2'b01,
        TERN_POS  = 2'b11
    } tern_e;

    // Detector pending flags
    typedef struct packed {
        logic up;
        logic dn;
    } pfd_t;

    localparam int NUM_OSC = 2;
    localparam int OSC_A   = 0;
    localparam int OSC_B   = 1;

    function automatic tern_e tern_encode(input logic active, input logic dir_up);
        tern_e r;
        if (!active)     r = TERN_ZERO;
        else if (dir_up) r = TERN_POS;
        else             r = TERN_NEG;
        return r;
    endfunction

endpackage

// File: rtl/pdi_edge.sv
module pdi_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic osc,
    output logic pulse
);
    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[CHAIN_W-2:0], osc};
    end

    // One-cycle pulse on a synchronized rising edge
    assign pulse = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    a_r1_single_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/pdi_clkgen.sv
module pdi_clkgen (
    input  logic clk,
    input  logic rst,
    input  logic pulse_a,
    input  logic pulse_b,
    output logic tick
);
    logic merged;
    logic half;

    assign merged = pulse_a | pulse_b;

    always_ff @(posedge clk) begin
        if (rst)         half <= 1'b0;
        else if (merged) half <= ~half;
    end

    // Rising edge of the halved merged-event clock
    assign tick = merged & ~half;

    a_r4_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    a_r4_needs_event: assert property (@(posedge clk) disable iff (rst)
        tick |-> (pulse_a || pulse_b));

endmodule

// File: rtl/pdi_pfd.sv
module pdi_pfd
    import pdi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pulse_a,
    input  logic pulse_b,
    input  logic tick,
    output pfd_t state,
    output logic sign
);
    logic only_a;
    logic only_b;
    logic raw_sign;
    pfd_t nxt;

    assign only_a = pulse_a & ~pulse_b;
    assign only_b = pulse_b & ~pulse_a;

    always_comb begin
        nxt.up = state.up | only_a;
        nxt.dn = state.dn | only_b;
        if (nxt.up && nxt.dn) nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= '0;
            raw_sign <= 1'b0;
            sign     <= 1'b0;
        end else begin
            state <= nxt;
            if (only_a && !state.dn)      raw_sign <= 1'b1;
            else if (only_b && !state.up) raw_sign <= 1'b0;
            if (tick) sign <= raw_sign;
        end
    end

    a_r2_a_raises_up: assert property (@(posedge clk) disable iff (rst)
        (only_a && !state.dn) |=> state.up);

    a_r2_b_raises_dn: assert property (@(posedge clk) disable iff (rst)
        (only_b && !state.up) |=> state.dn);

    a_r2_answer_clears: assert property (@(posedge clk) disable iff (rst)
        (only_b && state.up) |=> (!state.up && !state.dn));

    a_r3_coincident_hold: assert property (@(posedge clk) disable iff (rst)
        (pulse_a && pulse_b) |=> ($stable(state) && $stable(raw_sign)));

    a_r5_sign_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(sign));

endmodule

// File: rtl/pdi_counter.sv
module pdi_counter #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             step_en,
    input  logic             dir_up,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] MID = CNT_W'(1) << (CNT_W - 1);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] t_up;
    logic [CNT_W-1:0] t_dn;
    logic [CNT_W-1:0] tog;
    logic             sat;
    logic             adv;

    assign sat = dir_up ? (&count) : ~(|count);
    assign adv = tick & step_en & ~sat;

    // Toggle-enable chain per bit, direction chosen by a mux
    for (genvar i = 0; i < CNT_W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign t_up[i] = 1'b1;
            assign t_dn[i] = 1'b1;
        end else begin : g_upper
            assign t_up[i] = t_up[i-1] &  count[i-1];
            assign t_dn[i] = t_dn[i-1] & ~count[i-1];
        end
        assign tog[i] = adv & (dir_up ? t_up[i] : t_dn[i]);

        always_ff @(posedge clk) begin
            if (rst) count[i] <= MID[i];
            else     count[i] <= count[i] ^ tog[i];
        end
    end

    a_r6_unit_step: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1
                  || count == $past(count) - 1'b1));

    a_r6_no_wrap_top: assert property (@(posedge clk) disable iff (rst)
        (count == TOP) |=> (count != '0));

    a_r6_no_wrap_bottom: assert property (@(posedge clk) disable iff (rst)
        (count == '0) |=> (count != TOP));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

endmodule

// File: rtl/pdi_top.sv
module pdi_top
    import pdi_pkg::*;
#(
    parameter int CNT_W       = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_a,
    input  logic             osc_b,
    output logic [CNT_W-1:0] count,
    output logic             sign,
    output logic [1:0]       tcode
);
    logic [NUM_OSC-1:0] osc_in;
    logic [NUM_OSC-1:0] pulse;
    logic               tick;
    logic               active;
    pfd_t               pfd_st;
    tern_e              tern;

    assign osc_in = {osc_b, osc_a};

    for (genvar k = 0; k < NUM_OSC; k++) begin : g_osc
        pdi_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk   (clk),
            .rst   (rst),
            .osc   (osc_in[k]),
            .pulse (pulse[k])
        );
    end

    pdi_clkgen u_clkgen (
        .clk     (clk),
        .rst     (rst),
        .pulse_a (pulse[OSC_A]),
        .pulse_b (pulse[OSC_B]),
        .tick    (tick)
    );

    pdi_pfd u_pfd (
        .clk     (clk),
        .rst     (rst),
        .pulse_a (pulse[OSC_A]),
        .pulse_b (pulse[OSC_B]),
        .tick    (tick),
        .state   (pfd_st),
        .sign    (sign)
    );

    assign active = pfd_st.up | pfd_st.dn;

    pdi_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .step_en (active),
        .dir_up  (sign),
        .count   (count)
    );

    assign tern  = tern_encode(active, sign);
    assign tcode = tern;

    a_r8_legal_code: assert property (@(posedge clk) disable iff (rst)
        tcode != 2'b10);

    a_r2_exclusive_flags: assert property (@(posedge clk) disable iff (rst)
        !(pfd_st.up && pfd_st.dn));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !active |-> (tcode == 2'b01));

endmodule

// File: tb/tb_pdi_top.sv
module tb_pdi_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 9;
    localparam int MID        = 256;
    localparam int TOPV       = 511;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             osc_a = 1'b0;
    logic             osc_b = 1'b0;
    logic [CNT_W-1:0] count;
    logic             sign;
    logic [1:0]       tcode;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // Reference model state
    bit ma1, ma2, ma3, mb1, mb2, mb3;
    bit m_up, m_dn, m_raw, m_sign, m_half;
    int m_cnt = MID;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdi_top #(.CNT_W(CNT_W)) dut (
        .clk   (clk),
        .rst   (rst),
        .osc_a (osc_a),
        .osc_b (osc_b),
        .count (count),
        .sign  (sign),
        .tcode (tcode)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: edge events, pending flags, halving, saturating integrate
    always @(posedge clk) begin
        bit ea, eb, ev, tk, nu, nd;
        if (rst) begin
            {ma1, ma2, ma3, mb1, mb2, mb3} = '0;
            {m_up, m_dn, m_raw, m_sign, m_half} = '0;
            m_cnt = MID;
        end else begin
            ea = ma2 && !ma3;
            eb = mb2 && !mb3;
            ev = ea || eb;
            tk = ev && !m_half;
            if (tk && (m_up || m_dn)) begin
                if (m_sign && m_cnt < TOPV) m_cnt++;
                else if (!m_sign && m_cnt > 0) m_cnt--;
            end
            if (tk) m_sign = m_raw;
            if (ea && !eb && !m_dn) m_raw = 1'b1;
            else if (eb && !ea && !m_up) m_raw = 1'b0;
            nu = m_up || (ea && !eb);
            nd = m_dn || (eb && !ea);
            if (nu && nd) begin nu = 0; nd = 0; end
            m_up = nu; m_dn = nd;
            if (ev) m_half = !m_half;
            ma3 = ma2; ma2 = ma1; ma1 = osc_a;
            mb3 = mb2; mb2 = mb1; mb1 = osc_b;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        int exp_code;
        if (!rst && !finished) begin
            exp_code = !(m_up || m_dn) ? 1 : (m_sign ? 3 : 0);
            check(count == CNT_W'(m_cnt), "R6 count vs model", int'(count), m_cnt);
            check(sign == m_sign, "R5 sign vs model", int'(sign), int'(m_sign));
            check(tcode == 2'(exp_code), "R8 code vs model", int'(tcode), exp_code);
        end
    end

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Free-running oscillators for n cycles
    task automatic run_osc(input int n, input int per_a, input int per_b, input int off_b);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            osc_a = (i % per_a) < (per_a / 2);
            osc_b = ((i + off_b) % per_b) < (per_b / 2);
        end
        @(negedge clk);
        osc_a = 1'b0;
        osc_b = 1'b0;
        wait_n(8);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        wait_n(3);
        // R7 reset state
        check(count == MID, "R7 reset count", int'(count), MID);
        check(sign == 1'b0, "R7 reset sign", int'(sign), 0);
        check(tcode == 2'b01, "R7 reset code", int'(tcode), 1);
        rst = 1'b0;
        wait_n(4);

        // Directed single edges: R1 latency, R2 flags, R4 skipping, R5 hand-over
        osc_a = 1'b1;
        wait_n(2);
        check(tcode == 2'b01, "R1 not visible after two cycles", int'(tcode), 1);
        wait_n(1);
        check(tcode == 2'b00, "R1 R2 UP visible at third cycle, sign 0", int'(tcode), 0);
        wait_n(3);
        osc_b = 1'b1;
        wait_n(3);
        check(tcode == 2'b01, "R2 answer clears both flags", int'(tcode), 1);
        check(count == MID, "R4 event on non-counting cycle leaves count", int'(count), MID);
        osc_a = 1'b0;
        osc_b = 1'b0;
        wait_n(4);
        osc_a = 1'b1;
        wait_n(3);
        check(sign == 1'b1, "R5 sign passed on counting cycle", int'(sign), 1);
        check(tcode == 2'b11, "R8 plus one code", int'(tcode), 3);
        check(count == MID, "R6 idle detector at tick gives no step", int'(count), MID);
        osc_b = 1'b1;
        wait_n(4);
        osc_a = 1'b0;
        osc_b = 1'b0;
        wait_n(6);

        // Identical in-phase oscillators: R3
        run_osc(2000, 16, 16, 0);
        check(count == MID, "R3 coincident edges keep count", int'(count), MID);
        check(sign == 1'b1, "R3 coincident edges keep sign", int'(sign), 1);

        // A faster: R9 rise, R6 top saturation
        run_osc(20000, 12, 20, 5);
        check(count > MID, "R9 A faster raises count", int'(count), MID + 1);
        check(count == TOPV, "R6 saturates at top", int'(count), TOPV);

        // B faster: R9 fall, R6 bottom saturation
        run_osc(30000, 20, 12, 3);
        check(count < MID, "R9 B faster lowers count", int'(count), MID - 1);
        check(count == 0, "R6 saturates at bottom", int'(count), 0);

        // Reset mid-run: R7
        fork
            run_osc(500, 12, 20, 0);
            begin
                wait_n(250);
                rst = 1'b1;
                wait_n(1);
                check(count == MID, "R7 reset mid-run count", int'(count), MID);
                check(tcode == 2'b01, "R7 reset mid-run code", int'(tcode), 1);
                rst = 1'b0;
            end
        join

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule